// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop has settled. It watches the reference and feedback rising edges that a phase frequency detector compares. It samples both in a fast system clock domain and measures, for every PFD cycle, how many system clock ticks separate the two edges. A cycle counts as in-window when that gap is smaller than a selectable lock window. The lock flag rises once a programmed number of consecutive in-window cycles has been seen.

Once the flag is set, the block applies hysteresis. Gaps that are larger than the lock window but no larger than twice the window leave the flag high. Only a gap beyond twice the window drops it. A missing edge is treated as a very large gap. A disable input parks the detector with the flag low. A debug output exposes the current run of consecutive in-window cycles.

Processing is split into three parts. Two synchronizers with edge detectors feed a gap-measuring state machine (idle, waiting for feedback, waiting for reference). That machine hands finished gaps to a lock state machine. The lock machine has three states:
- off: moves to seek when disable is released.
- seek: moves to locked when the run reaches its target.
- locked: moves back to seek on a gap beyond the unlock threshold.

Any state moves to off while disable is high.

Top module: `pll_lock_detect`

## Requirements
- R1: Each in-window PFD cycle seen while unlocked raises `run_count` by exactly one.
- R2: `cfg_count_sel` sets the run needed for lock: 2'b00 needs 5 cycles, 2'b01 needs 16, 2'b10 needs 64 and 2'b11 needs 255. `lock_flag` rises together with `run_count` reaching that value, and `run_count` holds there while locked.
- R3: A cycle is in-window only when the gap is strictly less than the window. The window is 8 ticks when `cfg_win_low` is 0 and 3 ticks when it is 1, so a gap equal to the window is out-of-window.
- R4: While unlocked, any out-of-window cycle returns `run_count` to 0.
- R5: While locked, a gap of up to twice the window keeps `lock_flag` high. A gap strictly greater than twice the window clears `lock_flag` and `run_count` to 0.
- R6: The gap is the absolute tick distance between the two rising edges, whichever input rises first. Edges that rise on the same tick give a gap of 0.
- R7: If the second edge of a pair does not arrive within 255 ticks of the first, the gap is taken as 255.
- R8: While `cfg_disable` is 1, `lock_flag` and `run_count` are 0 from the next clock on, and edges are ignored. After `cfg_disable` returns to 0, counting starts again from zero.
- R9: After reset, `lock_flag` is 0 and `run_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both edge inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference signal at the phase detector |
| fb_in | input | 1 | Feedback (divided oscillator) signal at the phase detector |
| cfg_count_sel | input | 2 | Consecutive-cycle requirement code |
| cfg_win_low | input | 1 | Window range select: 0 = 8 ticks, 1 = 3 ticks |
| cfg_disable | input | 1 | 1 forces the detector off |
| lock_flag | output | 1 | Lock indication |
| run_count | output | 8 | Current consecutive in-window run (debug) |

## Verification
Four clock edges pass from the input that closes a pair to a changed `lock_flag`/`run_count`: two synchronizer flops, the registered gap and the lock register. A missing edge resolves about 257 edges after the opening edge instead. A disable takes effect on the next edge.

The bench drives one PFD cycle at a time. It keeps the inputs quiet for at least ten cycles after the last edge, and for the 280-cycle timeout case, before it pushes the expected flag and run into the scoreboard. Every comparison therefore lands well after its result is due and before the next pair begins.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

    localparam int RUN_W = 8;
    localparam int GAP_W = 8;

    localparam logic [RUN_W-1:0] NEED_SEL0 = RUN_W'(5);
    localparam logic [RUN_W-1:0] NEED_SEL1 = RUN_W'(16);
    localparam logic [RUN_W-1:0] NEED_SEL2 = RUN_W'(64);
    localparam logic [RUN_W-1:0] NEED_SEL3 = RUN_W'(255);

    typedef enum logic [1:0] {
        G_IDLE     = 2'd0,
        G_WAIT_FB  = 2'd1,
        G_WAIT_REF = 2'd2
    } gap_state_e;

    typedef enum logic [1:0] {
        L_OFF    = 2'd0,
        L_SEEK   = 2'd1,
        L_LOCKED = 2'd2
    } lock_state_e;

    function automatic logic [RUN_W-1:0] run_target(input logic [1:0] sel);
        logic [RUN_W-1:0] t;
        unique case (sel)
            2'b00:   t = NEED_SEL0;
            2'b01:   t = NEED_SEL1;
            2'b10:   t = NEED_SEL2;
            default: t = NEED_SEL3;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/lkd_edge_sync.sv
module lkd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[TOP];
        end
    end

    assign rise = chain[TOP] & ~last;

endmodule

// File: rtl/lkd_gap_meter.sv
module lkd_gap_meter
    import lkd_pkg::*;
#(
    parameter int W = GAP_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ref_rise,
    input  logic         fb_rise,
    output logic         gap_valid,
    output logic [W-1:0] gap_val
);
    localparam logic [W-1:0] CAP = '1;

    gap_state_e   state, state_n;
    logic [W-1:0] ticks;
    logic         closing;
    logic         at_cap;

    // Edge that ends the measurement in the current waiting state
    always_comb begin
        closing = 1'b0;
        unique case (state)
            G_WAIT_FB:  closing = fb_rise;
            G_WAIT_REF: closing = ref_rise;
            default:    closing = 1'b0;
        endcase
    end

    assign at_cap = (ticks == CAP);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) state <= G_IDLE;
        else               state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        unique case (state)
            G_IDLE: begin
                if (ref_rise && fb_rise) state_n = G_IDLE;
                else if (ref_rise)       state_n = G_WAIT_FB;
                else if (fb_rise)        state_n = G_WAIT_REF;
            end
            G_WAIT_FB, G_WAIT_REF: begin
                if (closing || at_cap) state_n = G_IDLE;
            end
            default: state_n = G_IDLE;
        endcase
    end

    // Tick counter and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks     <= '0;
            gap_valid <= 1'b0;
            gap_val   <= '0;
        end else if (clr) begin
            ticks     <= '0;
            gap_valid <= 1'b0;
        end else begin
            gap_valid <= 1'b0;
            unique case (state)
                G_IDLE: begin
                    if (ref_rise && fb_rise) begin
                        gap_valid <= 1'b1;
                        gap_val   <= '0;
                    end else if (ref_rise || fb_rise) begin
                        ticks <= W'(1);
                    end
                end
                G_WAIT_FB, G_WAIT_REF: begin
                    if (closing) begin
                        gap_valid <= 1'b1;
                        gap_val   <= ticks;
                    end else if (at_cap) begin
                        gap_valid <= 1'b1;
                        gap_val   <= CAP;
                    end else begin
                        ticks <= ticks + W'(1);
                    end
                end
                default: ticks <= '0;
            endcase
        end
    end

endmodule

// File: rtl/lkd_lock_fsm.sv
module lkd_lock_fsm
    import lkd_pkg::*;
#(
    parameter int WIN_HI = 8,
    parameter int WIN_LO = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gap_valid,
    input  logic [GAP_W-1:0] gap_val,
    input  logic [1:0]       count_sel,
    input  logic             win_low,
    input  logic             det_off,
    output logic             lock_flag,
    output logic [RUN_W-1:0] run_count
);
    localparam int XW = GAP_W + 1;
    localparam logic [XW-1:0] WIN_HI_T = XW'(WIN_HI);
    localparam logic [XW-1:0] WIN_LO_T = XW'(WIN_LO);

    lock_state_e      state, state_n;
    logic [XW-1:0]    window;
    logic [XW-1:0]    unlock_lim;
    logic [XW-1:0]    gap_x;
    logic             in_win;
    logic             too_far;
    logic [RUN_W-1:0] target;
    logic [RUN_W:0]   run_inc;
    logic             reach;

    assign window     = win_low ? WIN_LO_T : WIN_HI_T;
    assign unlock_lim = {window[XW-2:0], 1'b0};
    assign gap_x      = {1'b0, gap_val};
    assign in_win     = gap_x < window;
    assign too_far    = gap_x > unlock_lim;
    assign target     = run_target(count_sel);
    assign run_inc    = {1'b0, run_count} + (RUN_W+1)'(1);
    assign reach      = run_inc >= {1'b0, target};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= L_OFF;
        else        state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        if (det_off) begin
            state_n = L_OFF;
        end else begin
            unique case (state)
                L_OFF:    state_n = L_SEEK;
                L_SEEK:   if (gap_valid && in_win && reach) state_n = L_LOCKED;
                L_LOCKED: if (gap_valid && too_far)         state_n = L_SEEK;
                default:  state_n = L_OFF;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_flag <= 1'b0;
            run_count <= '0;
        end else begin
            lock_flag <= (state_n == L_LOCKED);
            if (det_off) begin
                run_count <= '0;
            end else begin
                unique case (state)
                    L_SEEK: begin
                        if (gap_valid) begin
                            if (!in_win)    run_count <= '0;
                            else if (reach) run_count <= target;
                            else            run_count <= run_inc[RUN_W-1:0];
                        end
                    end
                    L_LOCKED: begin
                        if (gap_valid && too_far) run_count <= '0;
                    end
                    default: run_count <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
    import lkd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WIN_HI      = 8,
    parameter int WIN_LO      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic [1:0]       cfg_count_sel,
    input  logic             cfg_win_low,
    input  logic             cfg_disable,
    output logic             lock_flag,
    output logic [RUN_W-1:0] run_count
);
    localparam int NUM_IN = 2;

    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] rise;
    logic              gap_valid;
    logic [GAP_W-1:0]  gap_val;

    assign raw_in = {fb_in, ref_in};

    for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
        lkd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[i]),
            .rise (rise[i])
        );
    end

    lkd_gap_meter #(.W(GAP_W)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_disable),
        .ref_rise (rise[0]),
        .fb_rise  (rise[1]),
        .gap_valid(gap_valid),
        .gap_val  (gap_val)
    );

    lkd_lock_fsm #(.WIN_HI(WIN_HI), .WIN_LO(WIN_LO)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .gap_valid(gap_valid),
        .gap_val  (gap_val),
        .count_sel(cfg_count_sel),
        .win_low  (cfg_win_low),
        .det_off  (cfg_disable),
        .lock_flag(lock_flag),
        .run_count(run_count)
    );

endmodule

// File: rtl/lkd_checker.sv
module lkd_checker
    import lkd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cfg_count_sel,
    input logic             cfg_disable,
    input logic             lock_flag,
    input logic [RUN_W-1:0] run_count,
    input logic             gap_valid
);
    // R1: the run never jumps by more than one per clock
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, run_count} <= {1'b0, $past(run_count)} + (RUN_W+1)'(1)));

    // R1: the run changes only after a finished gap or a disable
    a_r1_moves_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(run_count) |-> ($past(gap_valid) || $past(cfg_disable)));

    // R2: lock is declared with the run at its programmed target
    a_r2_lock_at_target: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> (run_count == run_target(cfg_count_sel)));

    // R2: lock only follows a measured gap
    a_r2_rise_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> $past(gap_valid));

    // R5: losing lock clears the run
    a_r5_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_flag) |-> (run_count == '0));

    // R8: disable parks the detector on the next clock
    a_r8_disable_parks: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_disable |=> (!lock_flag && run_count == '0));

endmodule

bind pll_lock_detect lkd_checker u_chk (.*);

// File: tb/pll_lock_detect_test.sv
module pll_lock_detect_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic [1:0] cfg_count_sel = 2'b00;
    logic       cfg_win_low = 1'b0;
    logic       cfg_disable = 1'b0;
    logic       lock_flag;
    logic [7:0] run_count;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Expectation queues (scoreboard)
    bit    q_flag[$];
    int    q_cnt[$];
    string q_tag[$];

    // Reference model state
    int  m_run = 0;
    bit  m_lock = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pll_lock_detect uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_in       (ref_in),
        .fb_in        (fb_in),
        .cfg_count_sel(cfg_count_sel),
        .cfg_win_low  (cfg_win_low),
        .cfg_disable  (cfg_disable),
        .lock_flag    (lock_flag),
        .run_count    (run_count)
    );

    function automatic int need_of(input logic [1:0] s);
        case (s)
            2'b00:   return 5;
            2'b01:   return 16;
            2'b10:   return 64;
            default: return 255;
        endcase
    endfunction

    task automatic push_exp(input string tag);
        q_flag.push_back(m_lock);
        q_cnt.push_back(m_run);
        q_tag.push_back(tag);
    endtask

    // One PFD cycle; d > 0 means feedback lags reference by d ticks
    task automatic pfd(input int d, input bit no_ref, input bit no_fb, input string tag);
        int r0, f0, len, gap, win;
        r0  = (d < 0) ? -d : 0;
        f0  = (d > 0) ? d : 0;
        len = ((r0 > f0) ? r0 : f0) + 14;
        if (no_ref || no_fb) len = 280;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            ref_in = !no_ref && (i >= r0) && (i < r0 + 4);
            fb_in  = !no_fb  && (i >= f0) && (i < f0 + 4);
        end
        gap = (no_ref || no_fb) ? 255 : ((d < 0) ? -d : d);
        win = cfg_win_low ? 3 : 8;
        if (cfg_disable) begin
            m_run = 0; m_lock = 1'b0;
        end else if (!m_lock) begin
            if (gap < win) begin
                m_run++;
                if (m_run >= need_of(cfg_count_sel)) begin
                    m_run = need_of(cfg_count_sel);
                    m_lock = 1'b1;
                end
            end else begin
                m_run = 0;
            end
        end else if (gap > 2 * win) begin
            m_lock = 1'b0; m_run = 0;
        end
        push_exp(tag);
    endtask

    // Monitor: pops expectations and compares with the outputs
    initial begin
        forever begin
            wait (q_flag.size() != 0);
            begin
                bit    ef;
                int    ec;
                string et;
                ef = q_flag.pop_front();
                ec = q_cnt.pop_front();
                et = q_tag.pop_front();
                checks++;
                if (lock_flag !== ef || int'(run_count) != ec) begin
                    errors++;
                    $display("FAIL %s: lock_flag=%0d run_count=%0d expected lock_flag=%0d run_count=%0d",
                             et, lock_flag, run_count, ef, ec);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push_exp("R9 reset state");

        // R1/R2: default need of 5, high window
        for (int k = 0; k < 5; k++) pfd(2, 0, 0, "R1 R2 count up to lock at 5");
        // R5: hysteresis in the high range (window 8, unlock above 16)
        pfd(12, 0, 0, "R5 gap 12 keeps lock");
        pfd(16, 0, 0, "R5 gap 16 keeps lock");
        pfd(17, 0, 0, "R5 gap 17 drops lock");
        // R6: simultaneous and feedback-first edges
        pfd(0, 0, 0, "R6 simultaneous edges in window");
        pfd(-5, 0, 0, "R6 feedback first gap 5");
        // R3/R4: gap equal to the window is out-of-window and clears run
        pfd(8, 0, 0, "R3 R4 gap equal to window clears run");
        pfd(7, 0, 0, "R3 gap 7 in window");
        pfd(30, 0, 0, "R4 far gap clears run");

        // R3/R5: low range
        @(negedge clk); cfg_win_low = 1'b1;
        pfd(3, 0, 0, "R3 low range gap 3 out of window");
        for (int k = 0; k < 5; k++) pfd(2, 0, 0, "R3 low range lock");
        pfd(6, 0, 0, "R5 low range gap 6 keeps lock");
        pfd(7, 0, 0, "R5 low range gap 7 drops lock");

        // R7: missing edges
        @(negedge clk); cfg_win_low = 1'b0;
        for (int k = 0; k < 5; k++) pfd(1, 0, 0, "R2 relock");
        pfd(0, 0, 1, "R7 missing feedback drops lock");
        pfd(1, 0, 0, "R7 counting resumes");
        pfd(1, 0, 0, "R7 counting resumes");
        pfd(0, 1, 0, "R7 missing reference clears run");

        // R8: disable
        for (int k = 0; k < 5; k++) pfd(1, 0, 0, "R8 lock before disable");
        @(negedge clk); cfg_disable = 1'b1;
        m_lock = 1'b0; m_run = 0;
        @(negedge clk); @(negedge clk);
        push_exp("R8 disable clears flag and run");
        for (int k = 0; k < 6; k++) pfd(1, 0, 0, "R8 edges ignored while disabled");
        @(negedge clk); cfg_disable = 1'b0;
        pfd(1, 0, 0, "R8 restart from zero");

        // R2: other count codes
        pfd(40, 0, 0, "R4 clear before code change");
        @(negedge clk); cfg_count_sel = 2'b01;
        for (int k = 0; k < 16; k++) pfd(1, 0, 0, "R2 code 01 needs 16");
        pfd(40, 0, 0, "R5 unlock before code change");
        @(negedge clk); cfg_count_sel = 2'b10;
        for (int k = 0; k < 64; k++) pfd(1, 0, 0, "R2 code 10 needs 64");
        pfd(40, 0, 0, "R5 unlock before code change");
        @(negedge clk); cfg_count_sel = 2'b11;
        for (int k = 0; k < 255; k++) pfd(0, 0, 0, "R2 code 11 needs 255");
        pfd(3, 0, 0, "R5 lock held at 255");

        wait (q_flag.size() == 0);
        @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule